// File: doc/BRIEF.md
# HDLC Event Status Latch

This block collects the event indications of an HDLC transmit path and receive path into one byte of sticky status bits. Pulse events (end of message leaving the transmit FIFO, transmit underrun, receive abort, receive packet start, receive packet end, receive overrun) set their bit in the cycle after they are seen. The two FIFO watermark indications are levels, and their bits set only when the level rises. A bit stays set until the host writes a 1 to its position.

Each bit can raise a single active-high interrupt line when its own enable bit and a global HDLC enable are both high. The enable byte and the global enable come from neighbouring registers. The interrupt line is registered, and it falls one clock after the last contributing bit clears or its enables are removed. Reset is an asynchronous active-low input that is synchronised inside the block before it releases the state.

Top module: `hdlc_evt_latch`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released, `stat_o` reads 0x00 and `irq_o` reads 0. Asserting `rst_n` clears them at once, without waiting for a clock edge.
- R2: A one-cycle pulse on `rx_abort_i`, `rx_sop_i`, `rx_eop_i` or `rx_ovr_i` sets bit 4, 5, 6 or 7 of `stat_o` on the next edge. The bit then stays set until it is cleared.
- R3: Bit 0 sets on a pulse of `tx_eom_i` or of `tx_udr_i`. Bit 1 sets only on a pulse of `tx_udr_i`.
- R4: Bit 2 follows `tx_low_i` and bit 3 follows `rx_high_i`, and each sets only when its level changes from 0 to 1. A level that stays high does not set its bit again after the bit is cleared.
- R5: A host write (`wr_en_i`=1) clears every status bit whose position in `wr_data_i` is 1. A bit whose position holds 0 is left unchanged.
- R6: If a set condition and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R7: `irq_o` becomes 1 one clock after any bit of `stat_o` is 1 with its bit of `bit_ie_i` at 1 and `glb_ie_i` at 1.
- R8: `irq_o` returns to 0 one clock after no bit meets that condition, whether because the bits were cleared, a per-bit enable dropped, or `glb_ie_i` dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_eom_i | input | 1 | Pulse: transmitter took a byte tagged end-of-message |
| tx_udr_i | input | 1 | Pulse: transmit FIFO underrun |
| tx_low_i | input | 1 | Level: transmit FIFO at or below low watermark |
| rx_high_i | input | 1 | Level: receive FIFO at or above high watermark |
| rx_abort_i | input | 1 | Pulse: abort sequence seen inside a packet |
| rx_sop_i | input | 1 | Pulse: receive packet start |
| rx_eop_i | input | 1 | Pulse: closing flag of a packet, good or bad |
| rx_ovr_i | input | 1 | Pulse: receive overrun |
| wr_en_i | input | 1 | Host write strobe for the status byte |
| wr_data_i | input | 8 | Host write data, 1 clears the bit |
| bit_ie_i | input | 8 | Per-bit interrupt enables |
| glb_ie_i | input | 1 | Global HDLC interrupt enable |
| stat_o | output | 8 | Latched status byte |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
The assertions assume that every event input and both watermark levels stay at 0 while reset is asserted and until the internal reset has released. Otherwise an event seen during the final reset edge would be dropped, and a check that looks one cycle back would misfire. The bench holds all inputs at zero through reset and for several clocks after it. Only then does it start its directed cases and its random phase. In the random phase, pulses, level flips, host writes and enable changes are drawn with low probability, so that set-versus-clear collisions and watermark edges all occur.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  localparam int STAT_W    = 8;
  localparam int NUM_LVL   = 2;
  localparam int SYNC_LEN  = 2;
  // bit positions of the status byte
  localparam int B_TX_EOM  = 0;
  localparam int B_TX_UDR  = 1;
  localparam int B_TX_LOW  = 2;
  localparam int B_RX_HIGH = 3;
  localparam int B_RX_ABT  = 4;
  localparam int B_RX_SOP  = 5;
  localparam int B_RX_EOP  = 6;
  localparam int B_RX_OVR  = 7;
  // index of each level input in the rise detector
  localparam int L_TX_LOW  = 0;
  localparam int L_RX_HIGH = 1;
endpackage

// File: rtl/hsl_rst_sync.sv
module hsl_rst_sync #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LEN-1];

  // R1: the synchronised reset can only rise after the raw reset was high
  p_release_r1: assert property (@(posedge clk) $rose(rst_sync_n) |-> rst_n);
endmodule

// File: rtl/hsl_rise_det.sv
module hsl_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  // R4: a held level produces a single rise, never two in a row
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/hsl_irq_gen.sv
module hsl_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] ie,
  input  logic         gie,
  output logic         irq
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = (|(stat & ie)) & gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R8: with the global enable removed the line is low one clock later
  p_gate_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq);
  // R8: with no enabled bit set the line is low one clock later
  p_bits_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ie) == '0) |=> !irq);
endmodule

// File: rtl/hdlc_evt_latch.sv
module hdlc_evt_latch
  import hsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_eom_i,
  input  logic              tx_udr_i,
  input  logic              tx_low_i,
  input  logic              rx_high_i,
  input  logic              rx_abort_i,
  input  logic              rx_sop_i,
  input  logic              rx_eop_i,
  input  logic              rx_ovr_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] bit_ie_i,
  input  logic              glb_ie_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic               rst_sync_n;
  logic [NUM_LVL-1:0] lvl_vec;
  logic [NUM_LVL-1:0] rise_vec;
  logic [STAT_W-1:0]  set_vec;
  logic [STAT_W-1:0]  clr_mask;
  logic [STAT_W-1:0]  stat_d;
  logic [STAT_W-1:0]  stat_q;
  logic               stat_en;

  hsl_rst_sync #(.LEN(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    lvl_vec           = '0;
    lvl_vec[L_TX_LOW]  = tx_low_i;
    lvl_vec[L_RX_HIGH] = rx_high_i;
  end

  hsl_rise_det #(.N(NUM_LVL)) u_rise (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (lvl_vec),
    .rise  (rise_vec)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_TX_EOM]  = tx_eom_i | tx_udr_i;
    set_vec[B_TX_UDR]  = tx_udr_i;
    set_vec[B_TX_LOW]  = rise_vec[L_TX_LOW];
    set_vec[B_RX_HIGH] = rise_vec[L_RX_HIGH];
    set_vec[B_RX_ABT]  = rx_abort_i;
    set_vec[B_RX_SOP]  = rx_sop_i;
    set_vec[B_RX_EOP]  = rx_eop_i;
    set_vec[B_RX_OVR]  = rx_ovr_i;
  end

  always_comb begin
    clr_mask = wr_en_i ? wr_data_i : '0;
    stat_en  = wr_en_i | (|set_vec);
    // a set in the same cycle overrides the clear
    stat_d   = (stat_q & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  hsl_irq_gen #(.W(STAT_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .stat  (stat_q),
    .ie    (bit_ie_i),
    .gie   (glb_ie_i),
    .irq   (irq_o)
  );

  assign stat_o = stat_q;

  // R2, R3: every bit that was set and not written 1 is still set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask)));
  // R6: a set event always lands, even against a clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat_q & $past(set_vec)) == $past(set_vec)));
  // R5: a bit written 1 without a set event reads 0
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat_q & $past(clr_mask & ~set_vec)) == '0));
  // R4: the low watermark bit only rises after a detected level edge
  p_low_edge_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(stat_q[B_TX_LOW]) |-> $past(rise_vec[L_TX_LOW]));
  // R7: the interrupt only rises when an enabled bit was set
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> ($past(|(stat_q & bit_ie_i)) && $past(glb_ie_i)));
endmodule

// File: tb/hdlc_evt_latch_tb.sv
module hdlc_evt_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_eom, tx_udr, tx_low, rx_high, rx_abort, rx_sop, rx_eop, rx_ovr;
  logic       wr_en, glb_ie;
  logic [7:0] wr_data, bit_ie, stat;
  logic       irq;

  logic [7:0] m_stat;
  logic       m_irq;
  logic [1:0] m_prev;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_evt_latch u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_eom_i(tx_eom), .tx_udr_i(tx_udr), .tx_low_i(tx_low), .rx_high_i(rx_high),
    .rx_abort_i(rx_abort), .rx_sop_i(rx_sop), .rx_eop_i(rx_eop), .rx_ovr_i(rx_ovr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .bit_ie_i(bit_ie), .glb_ie_i(glb_ie),
    .stat_o(stat), .irq_o(irq)
  );

  // expected next status byte from the requirement text
  function automatic logic [7:0] f_next(input logic [7:0] old, input logic [1:0] prev);
    logic [7:0] s;
    logic [7:0] c;
    s = {rx_ovr, rx_eop, rx_sop, rx_abort, rx_high & ~prev[1], tx_low & ~prev[0],
         tx_udr, tx_eom | tx_udr};
    c = wr_en ? wr_data : 8'h00;
    return (old & ~c) | s;
  endfunction

  function automatic logic f_irq(input logic [7:0] s);
    return (|(s & bit_ie)) & glb_ie;
  endfunction

  task automatic idle_inputs();
    tx_eom = 0; tx_udr = 0; rx_abort = 0; rx_sop = 0; rx_eop = 0; rx_ovr = 0;
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic check(input string tag);
    n_vec++;
    if (stat !== m_stat || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s stat=%h irq=%b expected stat=%h irq=%b", tag, stat, irq, m_stat, m_irq);
    end
  endtask

  // inputs are set at a falling edge; one rising edge; compare at next falling edge
  task automatic step(input string tag);
    @(posedge clk);
    m_irq  = f_irq(m_stat);
    m_stat = f_next(m_stat, m_prev);
    m_prev = {rx_high, tx_low};
    @(negedge clk);
    check(tag);
    idle_inputs();
  endtask

  task automatic expect_const(input string tag, input logic [7:0] es, input logic ei);
    n_vec++;
    if (stat !== es || irq !== ei) begin
      n_bad++;
      $display("FAIL %s stat=%h irq=%b expected stat=%h irq=%b", tag, stat, irq, es, ei);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the end of the run");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    idle_inputs();
    tx_low = 0; rx_high = 0; bit_ie = 8'h00; glb_ie = 0;
    m_stat = 0; m_irq = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    expect_const("R1 during reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_const("R1 after release", 8'h00, 1'b0);

    // R2: pulse event sets and holds
    rx_abort = 1; step("R2 abort sets bit4");
    step("R2 bit4 holds");
    expect_const("R2 sticky value", 8'h10, 1'b0);
    // R5: writing zeros leaves bits, writing one clears
    wr_en = 1; wr_data = 8'hEF; step("R5 zero write keeps bit4");
    wr_en = 1; wr_data = 8'h10; step("R5 one write clears bit4");
    expect_const("R5 cleared", 8'h00, 1'b0);
    // R3: underrun sets bits 0 and 1, end-of-message only bit 0
    tx_udr = 1; step("R3 underrun");
    expect_const("R3 underrun value", 8'h03, 1'b0);
    wr_en = 1; wr_data = 8'h03; step("R5 clear tx bits");
    tx_eom = 1; step("R3 eom");
    expect_const("R3 eom value", 8'h01, 1'b0);
    wr_en = 1; wr_data = 8'hFF; step("R5 clear all");
    // R4: watermark edge behaviour
    tx_low = 1; step("R4 low rises");
    wr_en = 1; wr_data = 8'h04; step("R4 clear while high");
    step("R4 held high no reset");
    step("R4 held high no reset again");
    expect_const("R4 stays clear", 8'h00, 1'b0);
    tx_low = 0; step("R4 low falls");
    tx_low = 1; rx_high = 1; step("R4 both rise");
    expect_const("R4 both set", 8'h0C, 1'b0);
    wr_en = 1; wr_data = 8'h0C; step("R5 clear marks");
    // R6: set beats clear in the same cycle
    rx_sop = 1; wr_en = 1; wr_data = 8'h20; step("R6 set wins");
    expect_const("R6 value", 8'h20, 1'b0);
    // R7: interrupt one clock after enable
    bit_ie = 8'h20; glb_ie = 1; step("R7 irq rises");
    expect_const("R7 irq up", 8'h20, 1'b1);
    // R8: drop on global disable, then on clear, then on bit disable
    glb_ie = 0; step("R8 global off");
    expect_const("R8 irq down gie", 8'h20, 1'b0);
    glb_ie = 1; step("R7 back on");
    wr_en = 1; wr_data = 8'h20; step("R8 clear bit");
    step("R8 irq follows clear");
    expect_const("R8 irq down clear", 8'h00, 1'b0);
    rx_eop = 1; step("R2 eop sets bit6");
    bit_ie = 8'h40; step("R7 irq via bit6");
    bit_ie = 8'h00; step("R8 per-bit enable off");
    expect_const("R8 irq down ie", 8'h40, 1'b0);

    // constrained random phase
    for (int i = 0; i < N_RANDOM; i++) begin
      tx_eom   = ($urandom_range(7) == 0);
      tx_udr   = ($urandom_range(15) == 0);
      rx_abort = ($urandom_range(11) == 0);
      rx_sop   = ($urandom_range(7) == 0);
      rx_eop   = ($urandom_range(7) == 0);
      rx_ovr   = ($urandom_range(15) == 0);
      if ($urandom_range(15) == 0) tx_low  = ~tx_low;
      if ($urandom_range(15) == 0) rx_high = ~rx_high;
      wr_en   = ($urandom_range(3) == 0);
      wr_data = 8'($urandom);
      if ($urandom_range(31) == 0) bit_ie = 8'($urandom);
      if ($urandom_range(31) == 0) glb_ie = ~glb_ie;
      step("R2/R3/R4/R5/R6/R7/R8 random");
    end

    // R1: asynchronous reset clears immediately
    rx_ovr = 1; step("R2 ovr before reset");
    bit_ie = 8'hFF; glb_ie = 1; step("R7 irq before reset");
    #1;
    rst_n = 1'b0;
    #1;
    expect_const("R1 async clear", 8'h00, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule